// File: doc/BRIEF.md
# Hash context register bank

This block is the software-visible state of a keyed-hash accelerator that lets a partial hash computation be saved and later resumed. It holds sixteen 32-bit chaining words, a 64-bit running message bit count, and sixteen secret key words. Software saves a context by reading the chaining words and both halves of the bit count. It restores the context by writing them back while the engine is stopped. The stored values are also driven out in parallel to the compression engine, which lies outside this block.

Access is through a single-beat 32-bit word-addressed port. Read data and the error flag appear one clock after the request is sampled. Two configuration bits pick the byte order independently for key words and for chaining words. Writes that would corrupt a live computation, writes to read-only or unmapped locations, and key writes during a key update are refused or flagged. The last error code stays readable.

Top module: `hctx_regbank`

## Requirements
- R1: After synchronous reset every stored word, the bit count, `rsp_rdata`, `err_pulse` and `err_code` are zero.
- R2: A write to word address 0x10+i (i in 0..15) while `cmd_active` is 0 stores a chaining word. It is driven on `digest_o[32*i +: 32]` and read back at the same address.
- R3: While `cfg_digest_swap` is 1, chaining words are byte-reversed on the way in and on the way out. While it is 0, they pass through unchanged.
- R4: Address 0x02 holds bits 31:0 and address 0x03 holds bits 63:32 of the bit count (`msglen_o`). A write to one half leaves the other half unchanged.
- R5: A write to 0x02, 0x03 or 0x10..0x1F while `cmd_active` is 1 is dropped and reports error code 1. This applies whatever the engine enable is.
- R6: A write to those same addresses while `cmd_active` is 0 and `cfg_engine_en` is 1 still takes effect, and reports error code 2.
- R7: A key write to 0x20+i stores the byte-reversed word on `key_o[32*i +: 32]` when `cfg_key_swap` is 0, and the word as written when it is 1. Key addresses read as zero with no error.
- R8: A key write while `key_busy` is 1 is dropped and reports error code 3.
- R9: Address 0x00 reads {29'b0, key_busy, cfg_engine_en, cmd_active} and address 0x01 reads the last error code. Writes to either change nothing and report error code 4.
- R10: Any other address reads as zero, ignores writes and reports error code 5.
- R11: Every error raises `err_pulse` for exactly the one cycle after the offending access. `err_code` then holds that code until the next error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| cfg_engine_en | input | 1 | Hash engine enabled |
| cfg_key_swap | input | 1 | Key byte order select |
| cfg_digest_swap | input | 1 | Chaining word byte order select |
| cmd_active | input | 1 | A hash command is in progress |
| key_busy | input | 1 | A key update is in progress |
| err_pulse | output | 1 | One-cycle error flag |
| err_code | output | 3 | Last reported error code |
| digest_o | output | 512 | Stored chaining words to the engine |
| key_o | output | 512 | Stored key words to the engine |
| msglen_o | output | 64 | Stored message bit count |

## Verification
Two gating conditions can hit the same write: a restore write can arrive while a command is still running and the engine enable is also set. The bench raises both inputs together before writing a chaining word and a length half. It expects the busy code (1) rather than the engine code (2), and it expects both stored values to be unchanged. It also writes a key word with the key-busy input and a swap mode set together, and expects the refusal to win over the byte reordering.

// File: rtl/hctx_pkg.sv
package hctx_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 7;
    localparam int IDX_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_ERRC   = 7'h01;
    localparam logic [ADDR_W-1:0] OFS_LEN_LO = 7'h02;
    localparam logic [ADDR_W-1:0] OFS_LEN_HI = 7'h03;
    localparam logic [ADDR_W-IDX_W-1:0] PAGE_DIGEST = 3'd1;
    localparam logic [ADDR_W-IDX_W-1:0] PAGE_KEY    = 3'd2;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_CMD_BUSY  = 3'd1,
        ERR_ENGINE_ON = 3'd2,
        ERR_KEY_BUSY  = 3'd3,
        ERR_READ_ONLY = 3'd4,
        ERR_UNMAPPED  = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        RGN_STATUS,
        RGN_ERRC,
        RGN_LEN_LO,
        RGN_LEN_HI,
        RGN_DIGEST,
        RGN_KEY,
        RGN_NONE
    } rgn_e;

    typedef struct packed {
        rgn_e             rgn;
        logic [IDX_W-1:0] idx;
    } dec_t;

    typedef struct packed {
        logic              len_lo_we;
        logic              len_hi_we;
        logic              dig_we;
        logic              key_we;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } wr_t;

    typedef struct packed {
        logic flag;
        err_e code;
    } errev_t;

    function automatic logic [WORD_W-1:0] bswap32(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/hctx_decode.sv
module hctx_decode
    import hctx_pkg::*;
#(
    parameter int DIGEST_WORDS = 16,
    parameter int KEY_WORDS    = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [ADDR_W-IDX_W-1:0] page;
    logic [IDX_W-1:0]        low;

    assign page = addr[ADDR_W-1:IDX_W];
    assign low  = addr[IDX_W-1:0];

    always_comb begin
        dec.idx = low;
        dec.rgn = RGN_NONE;
        if (addr == OFS_STATUS) begin
            dec.rgn = RGN_STATUS;
        end else if (addr == OFS_ERRC) begin
            dec.rgn = RGN_ERRC;
        end else if (addr == OFS_LEN_LO) begin
            dec.rgn = RGN_LEN_LO;
        end else if (addr == OFS_LEN_HI) begin
            dec.rgn = RGN_LEN_HI;
        end else if (page == PAGE_DIGEST && int'(low) < DIGEST_WORDS) begin
            dec.rgn = RGN_DIGEST;
        end else if (page == PAGE_KEY && int'(low) < KEY_WORDS) begin
            dec.rgn = RGN_KEY;
        end
    end
endmodule

// File: rtl/hctx_guard.sv
module hctx_guard
    import hctx_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  dec_t              dec,
    input  logic [WORD_W-1:0] wdata,
    input  logic              cmd_active,
    input  logic              engine_en,
    input  logic              key_busy,
    input  logic              key_swap,
    input  logic              digest_swap,
    output wr_t               wr,
    output errev_t            ev
);
    always_comb begin
        wr      = '0;
        ev.flag = 1'b0;
        ev.code = ERR_NONE;
        wr.idx  = dec.idx;
        wr.data = wdata;
        if (req_valid) begin
            case (dec.rgn)
                RGN_NONE: begin
                    ev.flag = 1'b1;
                    ev.code = ERR_UNMAPPED;
                end
                RGN_STATUS, RGN_ERRC: begin
                    if (req_write) begin
                        ev.flag = 1'b1;
                        ev.code = ERR_READ_ONLY;
                    end
                end
                RGN_LEN_LO, RGN_LEN_HI, RGN_DIGEST: begin
                    if (req_write) begin
                        if (cmd_active) begin
                            ev.flag = 1'b1;
                            ev.code = ERR_CMD_BUSY;
                        end else begin
                            if (engine_en) begin
                                ev.flag = 1'b1;
                                ev.code = ERR_ENGINE_ON;
                            end
                            wr.len_lo_we = (dec.rgn == RGN_LEN_LO);
                            wr.len_hi_we = (dec.rgn == RGN_LEN_HI);
                            wr.dig_we    = (dec.rgn == RGN_DIGEST);
                            if (dec.rgn == RGN_DIGEST && digest_swap) begin
                                wr.data = bswap32(wdata);
                            end
                        end
                    end
                end
                RGN_KEY: begin
                    if (req_write) begin
                        if (key_busy) begin
                            ev.flag = 1'b1;
                            ev.code = ERR_KEY_BUSY;
                        end else begin
                            wr.key_we = 1'b1;
                            wr.data   = key_swap ? wdata : bswap32(wdata);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hctx_store.sv
module hctx_store
    import hctx_pkg::*;
#(
    parameter int DIGEST_WORDS = 16,
    parameter int KEY_WORDS    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_t                 wr,
    output logic [WORD_W-1:0]   dig_q [DIGEST_WORDS],
    output logic [WORD_W-1:0]   key_q [KEY_WORDS],
    output logic [2*WORD_W-1:0] len_q
);
    logic [WORD_W-1:0] len_lo_q;
    logic [WORD_W-1:0] len_hi_q;

    for (genvar i = 0; i < DIGEST_WORDS; i++) begin : g_dig
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr.dig_we && wr.idx == IDX_W'(i)) begin
                word_q <= wr.data;
            end
        end
        assign dig_q[i] = word_q;
    end

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr.key_we && wr.idx == IDX_W'(i)) begin
                word_q <= wr.data;
            end
        end
        assign key_q[i] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_lo_q <= '0;
            len_hi_q <= '0;
        end else begin
            if (wr.len_lo_we) len_lo_q <= wr.data;
            if (wr.len_hi_we) len_hi_q <= wr.data;
        end
    end

    assign len_q = {len_hi_q, len_lo_q};

    AST_LEN_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        (wr.len_lo_we && !wr.len_hi_we) |=> (len_q[2*WORD_W-1:WORD_W] == $past(len_q[2*WORD_W-1:WORD_W]))); // R4
    AST_LEN_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        (wr.len_hi_we && !wr.len_lo_we) |=> (len_q[WORD_W-1:0] == $past(len_q[WORD_W-1:0]))); // R4
endmodule

// File: rtl/hctx_regbank.sv
module hctx_regbank
    import hctx_pkg::*;
#(
    parameter int DIGEST_WORDS = 16,
    parameter int KEY_WORDS    = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [WORD_W-1:0]              req_wdata,
    output logic [WORD_W-1:0]              rsp_rdata,
    input  logic                           cfg_engine_en,
    input  logic                           cfg_key_swap,
    input  logic                           cfg_digest_swap,
    input  logic                           cmd_active,
    input  logic                           key_busy,
    output logic                           err_pulse,
    output logic [2:0]                     err_code,
    output logic [DIGEST_WORDS*WORD_W-1:0] digest_o,
    output logic [KEY_WORDS*WORD_W-1:0]    key_o,
    output logic [2*WORD_W-1:0]            msglen_o
);
    localparam int STAT_PAD = WORD_W - 3;

    dec_t              dec;
    wr_t               wr;
    errev_t            ev;
    logic [WORD_W-1:0] dig_q [DIGEST_WORDS];
    logic [WORD_W-1:0] key_q [KEY_WORDS];
    logic [WORD_W-1:0] rd_word;
    err_e              err_q;

    hctx_decode #(
        .DIGEST_WORDS(DIGEST_WORDS),
        .KEY_WORDS   (KEY_WORDS)
    ) u_decode (
        .addr(req_addr),
        .dec (dec)
    );

    hctx_guard u_guard (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .dec        (dec),
        .wdata      (req_wdata),
        .cmd_active (cmd_active),
        .engine_en  (cfg_engine_en),
        .key_busy   (key_busy),
        .key_swap   (cfg_key_swap),
        .digest_swap(cfg_digest_swap),
        .wr         (wr),
        .ev         (ev)
    );

    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cmd_active &&
         (dec.rgn == RGN_DIGEST || dec.rgn == RGN_LEN_LO || dec.rgn == RGN_LEN_HI))
        |=> ($stable(digest_o) && $stable(msglen_o) && err_pulse && err_code == 3'd1)); // R5
    AST_KEY_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && key_busy && dec.rgn == RGN_KEY)
        |=> ($stable(key_o) && err_code == 3'd3)); // R8
    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && (dec.rgn == RGN_STATUS || dec.rgn == RGN_ERRC))
        |=> ($stable(digest_o) && $stable(key_o) && $stable(msglen_o))); // R9

    hctx_store #(
        .DIGEST_WORDS(DIGEST_WORDS),
        .KEY_WORDS   (KEY_WORDS)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .dig_q(dig_q),
        .key_q(key_q),
        .len_q(msglen_o)
    );

    for (genvar i = 0; i < DIGEST_WORDS; i++) begin : g_dig_out
        assign digest_o[i*WORD_W +: WORD_W] = dig_q[i];
    end
    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key_out
        assign key_o[i*WORD_W +: WORD_W] = key_q[i];
    end

    always_comb begin
        rd_word = '0;
        case (dec.rgn)
            RGN_STATUS: rd_word = {{STAT_PAD{1'b0}}, key_busy, cfg_engine_en, cmd_active};
            RGN_ERRC:   rd_word = {{STAT_PAD{1'b0}}, err_q};
            RGN_LEN_LO: rd_word = msglen_o[WORD_W-1:0];
            RGN_LEN_HI: rd_word = msglen_o[2*WORD_W-1:WORD_W];
            RGN_DIGEST: rd_word = cfg_digest_swap ? bswap32(dig_q[dec.idx]) : dig_q[dec.idx];
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
            err_q     <= ERR_NONE;
        end else begin
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
            err_pulse <= ev.flag;
            if (ev.flag) begin
                err_q <= ev.code;
            end
        end
    end

    assign err_code = err_q;

    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && dec.rgn == RGN_KEY) |=> (rsp_rdata == '0)); // R7
    AST_UNMAPPED_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && dec.rgn == RGN_NONE) |=> (err_pulse && err_code == 3'd5 && rsp_rdata == '0)); // R10
    AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(req_valid)); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (msglen_o == '0 && err_code == 3'd0 && !err_pulse && rsp_rdata == '0)); // R1
endmodule

// File: tb/hctx_regbank_bench.sv
`timescale 1ns/1ps
module hctx_regbank_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [6:0]   req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic         eng = 1'b0;
    logic         kswap = 1'b0;
    logic         dswap = 1'b0;
    logic         cact = 1'b0;
    logic         kbusy = 1'b0;
    logic         err_pulse;
    logic [2:0]   err_code;
    logic [511:0] digest_o;
    logic [511:0] key_o;
    logic [63:0]  msglen_o;

    always #4 clk = ~clk;

    hctx_regbank u_hctx_regbank (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .rsp_rdata      (rsp_rdata),
        .cfg_engine_en  (eng),
        .cfg_key_swap   (kswap),
        .cfg_digest_swap(dswap),
        .cmd_active     (cact),
        .key_busy       (kbusy),
        .err_pulse      (err_pulse),
        .err_code       (err_code),
        .digest_o       (digest_o),
        .key_o          (key_o),
        .msglen_o       (msglen_o)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] data;
        bit          err;
        logic [2:0]  code;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_dig [16];
    logic [31:0] m_key [16];
    logic [63:0] m_len;
    logic [2:0]  m_err;
    int          checks = 0;
    int          fails = 0;
    bit          pend = 1'b0;
    bit          done = 1'b0;

    function automatic logic [31:0] bs(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [6:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        logic [2:0] c;
        c = 3'd0;
        if (a == 7'h00 || a == 7'h01) begin
            c = 3'd4;
        end else if (a == 7'h02 || a == 7'h03 || a[6:4] == 3'd1) begin
            if (cact) begin
                c = 3'd1;
            end else begin
                if (eng) c = 3'd2;
                if (a == 7'h02) m_len[31:0] = d;
                else if (a == 7'h03) m_len[63:32] = d;
                else m_dig[a[3:0]] = dswap ? bs(d) : d;
            end
        end else if (a[6:4] == 3'd2) begin
            if (kbusy) c = 3'd3;
            else m_key[a[3:0]] = kswap ? d : bs(d);
        end else begin
            c = 3'd5;
        end
        if (c != 3'd0) m_err = c;
        e.is_rd = 1'b0; e.data = '0; e.err = (c != 3'd0); e.code = m_err; e.tag = tag;
        q.push_back(e);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_rd(input logic [6:0] a, input string tag);
        exp_t e;
        logic [31:0] v;
        bit bad;
        bad = 1'b0;
        v = '0;
        if (a == 7'h00) v = {29'b0, kbusy, eng, cact};
        else if (a == 7'h01) v = {29'b0, m_err};
        else if (a == 7'h02) v = m_len[31:0];
        else if (a == 7'h03) v = m_len[63:32];
        else if (a[6:4] == 3'd1) v = dswap ? bs(m_dig[a[3:0]]) : m_dig[a[3:0]];
        else if (a[6:4] == 3'd2) v = '0;
        else bad = 1'b1;
        if (bad) m_err = 3'd5;
        e.is_rd = 1'b1; e.data = v; e.err = bad; e.code = m_err; e.tag = tag;
        q.push_back(e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) pend <= req_valid;

    always @(negedge clk) begin
        if (pend && !rst) begin
            if (q.size() == 0) begin
                chk(64'd1, 64'd0, "scoreboard empty");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.is_rd) chk(rsp_rdata, e.data, {e.tag, " rdata"});
                chk(err_pulse, e.err, {e.tag, " err_pulse"});
                chk(err_code, e.code, {e.tag, " err_code"});
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1..all actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_dig[i] = '0;
            m_key[i] = '0;
        end
        m_len = '0;
        m_err = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_rdata, 0, "R1 rdata");
        chk(err_pulse, 0, "R1 err_pulse");
        chk(err_code, 0, "R1 err_code");
        chk(msglen_o, 0, "R1 msglen");
        chk(digest_o[63:0], 0, "R1 digest");
        chk(key_o[63:0], 0, "R1 key");
        do_rd(7'h00, "R1 status");
        do_rd(7'h15, "R1 digest5");

        // R2: plain chaining word store and readback
        do_wr(7'h10, 32'h1122_3344, "R2 wr d0");
        do_wr(7'h1F, 32'hA5A5_0F0F, "R2 wr d15");
        do_rd(7'h10, "R2 rd d0");
        do_rd(7'h1F, "R2 rd d15");
        idle(2);
        chk(digest_o[31:0], 32'h1122_3344, "R2 digest_o w0");
        chk(digest_o[511:480], 32'hA5A5_0F0F, "R2 digest_o w15");

        // R3: digest byte swap
        dswap = 1'b1;
        do_rd(7'h10, "R3 swapped read d0");
        do_wr(7'h13, 32'hDEAD_BEEF, "R3 swapped write d3");
        do_rd(7'h13, "R3 read back d3");
        idle(2);
        chk(digest_o[127:96], 32'hEFBE_ADDE, "R3 stored d3");
        dswap = 1'b0;
        do_rd(7'h13, "R3 unswapped read d3");

        // R4: length halves
        do_wr(7'h02, 32'h89AB_CDEF, "R4 wr lo");
        do_wr(7'h03, 32'h0123_4567, "R4 wr hi");
        idle(2);
        chk(msglen_o, 64'h0123_4567_89AB_CDEF, "R4 msglen");
        do_wr(7'h02, 32'h0000_0040, "R4 wr lo keeps hi");
        do_rd(7'h03, "R4 rd hi");
        do_rd(7'h02, "R4 rd lo");
        idle(2);
        chk(msglen_o, 64'h0123_4567_0000_0040, "R4 msglen after lo");

        // R5: busy and engine-enable together; busy wins, write dropped
        cact = 1'b1; eng = 1'b1;
        do_wr(7'h11, 32'h5555_AAAA, "R5 wr d1 busy");
        do_wr(7'h03, 32'hFFFF_FFFF, "R5 wr hi busy");
        do_rd(7'h11, "R5 rd d1");
        idle(2);
        chk(msglen_o, 64'h0123_4567_0000_0040, "R5 msglen kept");
        chk(digest_o[63:32], 32'h0, "R5 d1 kept");

        // R6: engine on, not busy: write lands with code 2
        cact = 1'b0;
        do_wr(7'h12, 32'h0BAD_F00D, "R6 wr d2 engine on");
        do_rd(7'h12, "R6 rd d2");
        eng = 1'b0;
        idle(2);
        chk(digest_o[95:64], 32'h0BAD_F00D, "R6 d2 stored");

        // R7: key swap modes and read masking
        kswap = 1'b0;
        do_wr(7'h20, 32'h0102_0304, "R7 key0 reversed");
        kswap = 1'b1;
        do_wr(7'h25, 32'hCAFE_F00D, "R7 key5 as written");
        do_rd(7'h20, "R7 key read zero");
        idle(2);
        chk(key_o[31:0], 32'h0403_0201, "R7 key_o w0");
        chk(key_o[191:160], 32'hCAFE_F00D, "R7 key_o w5");

        // R8: key busy with swap mode set
        kbusy = 1'b1; kswap = 1'b0;
        do_wr(7'h20, 32'hFFFF_FFFF, "R8 key0 busy");
        idle(2);
        chk(key_o[31:0], 32'h0403_0201, "R8 key0 kept");

        // R9: read-only status and error code
        cact = 1'b1;
        do_wr(7'h00, 32'hFFFF_FFFF, "R9 wr status");
        do_wr(7'h01, 32'h0000_0007, "R9 wr errc");
        do_rd(7'h00, "R9 rd status");
        do_rd(7'h01, "R9 rd errc");
        cact = 1'b0; kbusy = 1'b0;
        idle(2);
        chk(msglen_o, 64'h0123_4567_0000_0040, "R9 msglen untouched");

        // R10: unmapped addresses
        do_rd(7'h05, "R10 rd unmapped");
        do_wr(7'h30, 32'h1234_5678, "R10 wr unmapped");
        idle(1);
        // R11: pulse lasts one cycle, code held
        chk(err_pulse, 0, "R11 pulse dropped");
        chk(err_code, 5, "R11 code held");
        do_rd(7'h12, "R11 good read keeps code");
        idle(2);
        chk(digest_o[95:64], 32'h0BAD_F00D, "R10 digest untouched");
        chk(key_o[191:160], 32'hCAFE_F00D, "R10 key untouched");
        chk(q.size(), 0, "R11 scoreboard drained");

        done = 1'b1;
        finish_run();
    end
endmodule